// File: doc/BRIEF.md
# Variable-Step Alternating Keystream Generator

This block produces a pseudo-random keystream, one bit per round, from three linear feedback shift registers. The first register (the control register) moves exactly once per round. At the start of each round its lowest bit picks which of the other two registers will move in that round. A step count, formed from three weighted bits read out of the control register, sets how many times that register moves. The register that is not picked does not move. When the round ends, the output bit is the XOR of the top bits of all three registers, and a one-cycle strobe marks it.

A synchronous load writes a seed into each register. A seed of zero is replaced by a fixed nonzero value, so that no register can get stuck. The enable input only gates the start of a new round. A round that has started always runs to the end. The bit rate depends on the seed: a round takes from two to nine cycles.

Top module: `asg_varstep`

## Requirements
- R1: After reset, and in the cycle after `load` is asserted, `valid` and `key` are 0 and the controller is idle. `load` writes `seed_a`, `seed_b` and `seed_c` into the control register A (64 bits) and the data registers B (41 bits) and C (43 bits). A seed that is all zero is replaced by the value 1. Reset sets all three registers to 1.
- R2: One step of a register shifts it one place toward its MSB. The new bit 0 is the XOR of the feedback taps: bits 63,62,60,59 for A, bits 40,37 for B and bits 42,41,37,36 for C. The output bit of each register is its MSB.
- R3: When bit 0 of A is 1 at the start of a round, B steps and C holds for the whole round. When it is 0, C steps and B holds.
- R4: The step count is computed from A at the start of the round. For B it is 1 + A[5] + 2·A[17] + 4·A[40]. For C it is 1 + A[9] + 2·A[28] + 4·A[55]. The count is therefore always between 1 and 8.
- R5: A steps exactly once per round, on the same cycle as the last step of B or C, and at no other time.
- R6: When a round completes, `key` equals A.MSB ^ B.MSB ^ C.MSB of the new register states, and `valid` is high for exactly one cycle.
- R7: With `en` held high, a round takes 1 + count cycles: one cycle to decide, then one cycle for each step. The `valid` pulses are spaced by that number of cycles.
- R8: While the controller is idle and `en` is low, no register moves and `valid` stays low. Dropping `en` in the middle of a round does not shorten or change that round.
- R9: `key` holds its value between `valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Write the seeds and return to idle |
| seed_a | input | 64 | Seed for control register A |
| seed_b | input | 41 | Seed for data register B |
| seed_c | input | 43 | Seed for data register C |
| en | input | 1 | Allow a new round to start |
| key | output | 1 | Keystream bit |
| valid | output | 1 | One-cycle strobe for a new keystream bit |

## Verification
The assertions assume that `load` is a clean single-cycle request that may arrive in any state. They also assume that `en` is sampled only by the idle controller, so its level during a round is irrelevant. The stimulus changes `load`, `en` and the seeds only on falling edges. It seeds all-zero registers on purpose, to reach the substitution path, and it drops `en` both while idle and during a round. A bench model of the registers and the count rule predicts every key bit and every gap between strobes.

// File: rtl/asg_pkg.sv
// Shared types for the variable-step alternating keystream generator.
// Assumes one round = one decide cycle followed by 1..2^W step cycles.
package asg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STEP_B = 2'd1,
        PH_STEP_C = 2'd2
    } phase_t;

    localparam int TAP_IDX_W = 6;
endpackage

// File: rtl/asg_lfsr.sv
// One Fibonacci shift register that shifts toward the MSB.
// The feedback enters at bit 0 and the output is the MSB. A load has
// priority over a step. A zero seed is replaced by FILL, which is
// assumed to be nonzero.
module asg_lfsr #(
    parameter int           L       = 41,
    parameter logic [L-1:0] FB_MASK = {1'b1, {(L-1){1'b0}}},
    parameter logic [L-1:0] FILL    = {{(L-1){1'b0}}, 1'b1}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [L-1:0] seed,
    input  logic         adv,
    output logic [L-1:0] state,
    output logic         msb_next
);
    logic [L-1:0] nxt;

    // Next state for one step: shift up, feedback into bit 0.
    always_comb nxt = {state[L-2:0], ^(state & FB_MASK)};

    // MSB as it will be after this cycle's edge (only meaningful without load).
    always_comb msb_next = adv ? state[L-2] : state[L-1];

    // State register: reset to FILL, load with zero substitution, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)          state <= FILL;
        else if (load)       state <= (seed == '0) ? FILL : seed;
        else if (adv)        state <= nxt;
    end

    // R1: a register never reaches the all-zero lock-up state.
    a_r1_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/asg_stepcount.sv
// Builds a step count of 1 + sum(2^k * r[idx_k]) for k in 0..W-1.
// Each 6-bit tap index is decoded one-hot and ANDed with the register
// contents. Assumes every index is below L.
module asg_stepcount #(
    parameter int                 L    = 64,
    parameter int                 W    = 3,
    parameter logic [W*6-1:0]     TAPS = '0
) (
    input  logic [L-1:0] r,
    output logic [W:0]   count
);
    import asg_pkg::*;

    logic [W-1:0] tap_bit;

    for (genvar k = 0; k < W; k++) begin : g_tap
        logic [TAP_IDX_W-1:0] idx;
        logic [L-1:0]         sel;
        assign idx = TAPS[k*TAP_IDX_W +: TAP_IDX_W];
        // Decode the index one-hot and pick the addressed bit.
        always_comb begin
            sel        = {{(L-1){1'b0}}, 1'b1} << idx;
            tap_bit[k] = |(r & sel);
        end
    end

    // Weighted sum: shift each tapped bit to its weight and accumulate.
    always_comb begin
        count = {{W{1'b0}}, 1'b1};
        for (int k = 0; k < W; k++)
            count = count + ({{W{1'b0}}, tap_bit[k]} << k);
    end
endmodule

// File: rtl/asg_varstep.sv
// Variable-step alternating keystream generator. In each round, control
// register A picks B or C by its bit 0. The picked register steps for a
// weighted count taken from A, and A steps once on the last step.
// The key bit is the XOR of the three MSBs after the round. Assumes
// inputs are synchronous to clk. en is sampled only while idle.
module asg_varstep #(
    parameter int              LA     = 64,
    parameter int              LB     = 41,
    parameter int              LC     = 43,
    parameter int              W      = 3,
    parameter logic [LA-1:0]   MASK_A = 64'hD800_0000_0000_0000,
    parameter logic [LB-1:0]   MASK_B = 41'h120_0000_0000,
    parameter logic [LC-1:0]   MASK_C = 43'h630_0000_0000,
    parameter logic [W*6-1:0]  TAPS_B = {6'd40, 6'd17, 6'd5},
    parameter logic [W*6-1:0]  TAPS_C = {6'd55, 6'd28, 6'd9}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LA-1:0] seed_a,
    input  logic [LB-1:0] seed_b,
    input  logic [LC-1:0] seed_c,
    input  logic          en,
    output logic          key,
    output logic          valid
);
    import asg_pkg::*;

    localparam int        CW   = W + 1;
    localparam logic [CW-1:0] CMAX = CW'(1) << W;
    localparam logic [CW-1:0] ONE  = CW'(1);

    phase_t          phase;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_b, cnt_c;
    logic [LA-1:0]   ra;
    logic [LB-1:0]   rb;
    logic [LC-1:0]   rc;
    logic            na, nb, nc;
    logic            adv_a, adv_b, adv_c, last_step;

    // Step enables: the picked register on each step cycle, A on the last.
    always_comb begin
        last_step = (phase != PH_IDLE) && (cnt == ONE);
        adv_a     = last_step;
        adv_b     = (phase == PH_STEP_B);
        adv_c     = (phase == PH_STEP_C);
    end

    asg_lfsr #(.L(LA), .FB_MASK(MASK_A), .FILL({{(LA-1){1'b0}}, 1'b1})) u_reg_a (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_a),
        .adv(adv_a), .state(ra), .msb_next(na));

    asg_lfsr #(.L(LB), .FB_MASK(MASK_B), .FILL({{(LB-1){1'b0}}, 1'b1})) u_reg_b (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_b),
        .adv(adv_b), .state(rb), .msb_next(nb));

    asg_lfsr #(.L(LC), .FB_MASK(MASK_C), .FILL({{(LC-1){1'b0}}, 1'b1})) u_reg_c (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_c),
        .adv(adv_c), .state(rc), .msb_next(nc));

    asg_stepcount #(.L(LA), .W(W), .TAPS(TAPS_B)) u_cnt_b (.r(ra), .count(cnt_b));
    asg_stepcount #(.L(LA), .W(W), .TAPS(TAPS_C)) u_cnt_c (.r(ra), .count(cnt_c));

    // Round controller: decide, count down the steps, emit the key bit.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            valid <= 1'b0;
            key   <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (en) begin
                        phase <= ra[0] ? PH_STEP_B : PH_STEP_C;
                        cnt   <= ra[0] ? cnt_b : cnt_c;
                    end
                end
                default: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) begin
                        phase <= PH_IDLE;
                        valid <= 1'b1;
                        key   <= na ^ nb ^ nc;
                    end
                end
            endcase
        end
    end

    // R3: C is frozen while B is stepping.
    a_r3_c_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEP_B && !load) |=> $stable(rc));
    // R3: B is frozen while C is stepping.
    a_r3_b_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEP_C && !load) |=> $stable(rb));
    // R4: a round's count is within 1..2^W.
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && en && !load) |=> (cnt >= ONE && cnt <= CMAX));
    // R5: A moves only on the final step of a round.
    a_r5_a_once: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !last_step) |=> $stable(ra));
    // R6: valid is a single-cycle pulse.
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R8: an idle controller with en low stays idle and silent.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !en && !load) |=> (phase == PH_IDLE && !valid));
    // R9: key changes only when a round completes.
    a_r9_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !last_step) |=> $stable(key));
endmodule

// File: tb/asg_varstep_tb.sv
// Self-checking bench: a behavioural model of the three registers and
// the count rule predicts every key bit and every round length.
module asg_varstep_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, load, en;
    logic [63:0] seed_a;
    logic [40:0] seed_b;
    logic [42:0] seed_c;
    logic        key, valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [63:0] ma, mb, mc;

    always #(CLK_PERIOD/2) clk = ~clk;

    asg_varstep u_dut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
        .en(en), .key(key), .valid(valid));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2 model step: shift up, feedback = XOR of masked bits, keep len bits.
    function automatic logic [63:0] mstep(input logic [63:0] r, input logic [63:0] m, input int len);
        logic fb;
        fb = ^(r & m);
        r  = {r[62:0], fb};
        return r & ((64'd1 << len) - 64'd1);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic do_load(input logic [63:0] a, input logic [40:0] b, input logic [42:0] c);
        @(negedge clk);
        en = 1'b0; load = 1'b1; seed_a = a; seed_b = b; seed_c = c;
        @(negedge clk);
        load = 1'b0;
        // R1: zero seeds become 1.
        ma = (a == 0) ? 64'd1 : a;
        mb = (b == 0) ? 64'd1 : {23'd0, b};
        mc = (c == 0) ? 64'd1 : {21'd0, c};
        chk(valid == 1'b0 && key == 1'b0, "R1 load clears outputs", {62'd0, valid, key}, 64'd0);
    endtask

    // One round: caller has en=1 at a negedge; the decide edge is next.
    task automatic run_round(input bit drop_mid);
        int d, n;
        logic exp_key, prev_key;
        bit held;
        // R3 R4: pick and count from A at the start of the round.
        if (ma[0]) d = 1 + ma[5] + 2*ma[17] + 4*ma[40];
        else       d = 1 + ma[9] + 2*ma[28] + 4*ma[55];
        for (int i = 0; i < d; i++) begin
            if (ma[0]) mb = mstep(mb, 64'h0000_0120_0000_0000, 41);
            else       mc = mstep(mc, 64'h0000_0630_0000_0000, 43);
        end
        ma = mstep(ma, 64'hD800_0000_0000_0000, 64); // R5: A once per round
        exp_key = ma[63] ^ mb[40] ^ mc[42];
        prev_key = key;
        held = 1'b1;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (drop_mid && n == 1) en = 1'b0;
            if (valid) break;
            if (key !== prev_key) held = 1'b0;
            if (n > 20) break;
        end
        chk(held, "R9 key held during round", {63'd0, key}, {63'd0, prev_key});
        chk(n == 1 + d, "R7 round length", n, 1 + d);
        chk(key == exp_key, "R6 key bit (R2 R3 R4 R5)", {63'd0, key}, {63'd0, exp_key});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] sa [5];
        logic [40:0] sb [5];
        logic [42:0] sc [5];
        logic k0;
        rst_n = 1'b0; load = 1'b0; en = 1'b0;
        seed_a = '0; seed_b = '0; seed_c = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0 && key == 1'b0, "R1 reset state", {62'd0, valid, key}, 64'd0);
        // R1: after reset the registers equal 1.
        ma = 64'd1; mb = 64'd1; mc = 64'd1;
        en = 1'b1;
        for (int r = 0; r < 30; r++) run_round(1'b0);

        sa[0] = 64'h0123_4567_89AB_CDEF; sb[0] = 41'h0AB_CDEF_0123; sc[0] = 43'h5A5_A5A5_A5A5;
        sa[1] = 64'hFFFF_FFFF_FFFF_FFFF; sb[1] = 41'h1FF_FFFF_FFFF; sc[1] = 43'h7FF_FFFF_FFFF;
        sa[2] = 64'd0;                    sb[2] = 41'd0;            sc[2] = 43'd0;
        sa[3] = 64'h8000_0000_0000_0000; sb[3] = 41'd0;            sc[3] = 43'h123_4567_89AB;
        sa[4] = 64'hDEAD_BEEF_0BAD_F00D; sb[4] = 41'h155_5555_5555; sc[4] = 43'd0;
        for (int s = 0; s < 5; s++) begin
            do_load(sa[s], sb[s], sc[s]);
            en = 1'b1;
            for (int r = 0; r < 40; r++) run_round(1'b0);
        end

        // R8: idle with en low: nothing moves, no strobe.
        en = 1'b0;
        k0 = key;
        repeat (6) begin
            @(negedge clk);
            chk(valid == 1'b0 && key == k0, "R8 idle with en low", {62'd0, valid, key}, {63'd0, k0});
        end
        en = 1'b1;
        run_round(1'b0);
        // R8: dropping en mid-round does not cut the round short.
        run_round(1'b1);
        k0 = key;
        repeat (5) begin
            @(negedge clk);
            chk(valid == 1'b0 && key == k0, "R8 idle after mid-round drop", {62'd0, valid, key}, {63'd0, k0});
        end
        en = 1'b1;
        for (int r = 0; r < 10; r++) run_round(1'b0);

        // R1: a load in the middle of a round restarts cleanly.
        @(negedge clk);
        do_load(64'h0F0F_0F0F_F0F0_F0F0, 41'h0C3_3C3C_C3C3, 43'h3CC_CC33_3333);
        en = 1'b1;
        for (int r = 0; r < 20; r++) run_round(1'b0);

        finish_run();
    end
endmodule